// File: doc/BRIEF.md
# Bit-Plane Transposer for Cascaded Shift-Out

This block widens the number of output lines a chip can drive by feeding a chain of external serial-in, parallel-out shift registers. Those registers are 8 bits each and can be cascaded to 16 or 32 bits. Only three wires leave the block: serial data, shift clock and latch strobe.

Software-side data arrives as one byte per output line, `LINES` bytes at a time. The block regroups the bytes into eight bit-planes. Plane `p` is a `LINES`-bit word that holds bit `p` of every byte. Each plane is clocked into the chain one bit at a time, and then the latch is pulsed so that all outputs change on the same edge.

A single valid/ready handshake paces the input. A new set of bytes is taken only after all eight planes have been latched. Each shift-and-latch burst is sized so that it fits inside one output time slot of `SLOT_CYC` clock cycles.

Top module: `bitplane_shiftout`

## Requirements
- R1: After reset, in_ready_o is 1 and sclk_o, latch_o and sdata_o are all 0.
- R2: When in_valid_i and in_ready_o are both high at a clock edge, in_data_i is captured. The byte for line k is taken from bits [8k+7:8k]. From the next cycle, in_ready_o stays low until the frame is finished.
- R3: While in_ready_o is low, in_valid_i and in_data_i are ignored. Data presented during a frame does not alter the bits that are shifted out.
- R4: Planes are sent in order from plane 0 (bit 0 of every byte) up to plane 7. Within a plane, the bit for line LINES-1 is shifted first and the bit for line 0 last. After a plane is latched, chain position k therefore holds line k.
- R5: Each bit occupies DIV cycles with sclk_o low, followed by DIV cycles with sclk_o high. sdata_o takes its new value only in the cycle where sclk_o falls or leaves idle, and it does not change while sclk_o is high.
- R6: After the LINES bits of a plane, latch_o is high for DIV cycles, with sclk_o low and sdata_o 0. sclk_o and latch_o are never high together, and each frame contains exactly 8 latch pulses.
- R7: in_ready_o returns to 1 exactly 8*(2*DIV*LINES+DIV) cycles after the accepting edge. An in_valid_i held high is then accepted at the next edge, with no extra gap.
- R8: The shift-and-latch burst of each plane completes in fewer than SLOT_CYC cycles.
- R9: Outside a frame, sdata_o, sclk_o and latch_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A set of line bytes is offered |
| in_ready_o | output | 1 | Block is idle and will take a byte set |
| in_data_i | input | 8*LINES | One byte per line; line k occupies bits [8k+7:8k] |
| sdata_o | output | 1 | Serial data to the register chain |
| sclk_o | output | 1 | Shift clock; the chain samples on its rising edge |
| latch_o | output | 1 | Latch strobe that moves the chain to its outputs |

## Verification
Two events can coincide in one cycle: a frame ending, shown by in_ready_o rising, and the next set of bytes being accepted. The bench provokes this by holding in_valid_i high across a whole frame, with new data already present when ready returns. It then checks that the new frame's first low-clock bit follows with no idle gap and that the data is the second set, not the first. It also holds in_valid_i high with different data throughout a frame. Every plane latched by the bench's model of the external register chain must still equal the data that was originally accepted.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_HIGH  = 2'd2,
    PH_LATCH = 2'd3
  } phase_e;

  localparam int unsigned NUM_PLANES = 8;
endpackage

// File: rtl/bpt_capture.sv
// Byte bank plus bit-plane selection (the transpose is pure wiring).
module bpt_capture #(
  parameter int unsigned LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [8*LINES-1:0] data_i,
  input  logic [2:0]         plane_i,
  output logic [LINES-1:0]   plane_word_o
);
  logic [8*LINES-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_q <= '0;
    else if (load_i) bank_q <= data_i;
  end

  for (genvar k = 0; k < LINES; k++) begin : g_line
    logic [7:0] byte_k;
    assign byte_k          = bank_q[8*k +: 8];
    assign plane_word_o[k] = byte_k[plane_i];
  end

  // R3: bank only moves on an accepted handshake
  a_r3_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(bank_q));
endmodule

// File: rtl/bpt_timer.sv
// Phase-length counter: every non-idle phase lasts DIV cycles.
module bpt_timer #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/bpt_seq.sv
// Plane/bit sequencer driving the three chain wires.
module bpt_seq
  import bpt_pkg::*;
#(
  parameter int unsigned LINES    = 16,
  parameter int unsigned SLOT_CYC = 625
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [LINES-1:0] plane_word_i,
  output logic [2:0]       plane_o,
  output logic             run_o,
  output logic             idle_o,
  output logic             sdata_o,
  output logic             sclk_o,
  output logic             latch_o
);
  localparam int unsigned IW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int unsigned BW = $clog2(SLOT_CYC + 1) + 1;
  localparam logic [IW-1:0] TOP_BIT = IW'(LINES - 1);

  phase_e        ph_q;
  logic [IW-1:0] bit_q;
  logic [2:0]    plane_q;
  logic [BW-1:0] burst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      bit_q   <= '0;
      plane_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q    <= PH_LOW;
          plane_q <= '0;
          bit_q   <= TOP_BIT;
        end
        PH_LOW: if (tick_i) ph_q <= PH_HIGH;
        PH_HIGH: if (tick_i) begin
          if (bit_q == '0) ph_q <= PH_LATCH;
          else begin
            bit_q <= bit_q - 1'b1;
            ph_q  <= PH_LOW;
          end
        end
        PH_LATCH: if (tick_i) begin
          if (plane_q == 3'(NUM_PLANES - 1)) ph_q <= PH_IDLE;
          else begin
            plane_q <= plane_q + 1'b1;
            bit_q   <= TOP_BIT;
            ph_q    <= PH_LOW;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // cycles spent on the current plane
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              burst_q <= '0;
    else if (ph_q == PH_IDLE)                 burst_q <= '0;
    else if (ph_q == PH_LATCH && tick_i)      burst_q <= '0;
    else                                      burst_q <= burst_q + 1'b1;
  end

  assign plane_o = plane_q;
  assign run_o   = (ph_q != PH_IDLE);
  assign idle_o  = (ph_q == PH_IDLE);
  assign sclk_o  = (ph_q == PH_HIGH);
  assign latch_o = (ph_q == PH_LATCH);
  assign sdata_o = (ph_q == PH_LOW || ph_q == PH_HIGH) ? plane_word_i[bit_q] : 1'b0;

  a_r8_slot_fit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (burst_q < BW'(SLOT_CYC)));

  a_r5_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdata_o));

  a_r9_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && $past(idle_o)) |-> (!sdata_o && !sclk_o && !latch_o));
endmodule

// File: rtl/bitplane_shiftout.sv
module bitplane_shiftout #(
  parameter int unsigned LINES    = 16,
  parameter int unsigned DIV      = 2,
  parameter int unsigned SLOT_CYC = 625
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [8*LINES-1:0] in_data_i,
  output logic               sdata_o,
  output logic               sclk_o,
  output logic               latch_o
);
  logic             load;
  logic             tick;
  logic             run;
  logic             idle;
  logic [2:0]       plane;
  logic [LINES-1:0] plane_word;

  assign in_ready_o = idle;
  assign load       = in_valid_i && idle;

  bpt_capture #(.LINES(LINES)) u_capture (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .data_i       (in_data_i),
    .plane_i      (plane),
    .plane_word_o (plane_word)
  );

  bpt_timer #(.DIV(DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  bpt_seq #(.LINES(LINES), .SLOT_CYC(SLOT_CYC)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (load),
    .tick_i       (tick),
    .plane_word_i (plane_word),
    .plane_o      (plane),
    .run_o        (run),
    .idle_o       (idle),
    .sdata_o      (sdata_o),
    .sclk_o       (sclk_o),
    .latch_o      (latch_o)
  );

  // latch pulses seen in the current frame
  logic       latch_d_q;
  logic       ready_d_q;
  logic [3:0] lat_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_d_q <= 1'b0;
      ready_d_q <= 1'b1;
      lat_cnt_q <= '0;
    end else begin
      latch_d_q <= latch_o;
      ready_d_q <= in_ready_o;
      if (load)                        lat_cnt_q <= '0;
      else if (latch_o && !latch_d_q)  lat_cnt_q <= lat_cnt_q + 1'b1;
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_o && latch_o));

  a_r6_eight_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !ready_d_q) |-> (lat_cnt_q == 4'd8));
endmodule

// File: tb/sim_bitplane_shiftout.sv
module sim_bitplane_shiftout;
  localparam int N     = 16;
  localparam int DIV   = 2;
  localparam int SLOT  = 625;
  localparam int FRAME = 8 * (2 * DIV * N + DIV);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [8*N-1:0] in_data = '0;
  logic           sdata, sclk, latch;

  always #4 clk = ~clk;

  bitplane_shiftout #(.LINES(N), .DIV(DIV), .SLOT_CYC(SLOT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .sdata_o(sdata), .sclk_o(sclk), .latch_o(latch)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [2:0]     expq[$];
  logic           acc_q = 1'b0;
  logic [8*N-1:0] data_q = '0;
  logic [8*N-1:0] fdata = '0;
  logic [N-1:0]   chain = '0;
  int             plane_exp = 0;
  int             pstart = 0;
  int             cyc = 0;
  int             frames = 0;
  bit             prev_sclk = 1'b0, prev_latch = 1'b0, was_busy = 1'b0;

  always @(posedge clk) begin
    acc_q  <= in_valid & in_ready;
    data_q <= in_data;
  end

  always @(posedge clk) begin
    cyc++;
    #2;
    if (rst_n) begin
      if (acc_q) begin
        fdata     = data_q;
        plane_exp = 0;
        pstart    = cyc;
        frames++;
        for (int p = 0; p < 8; p++) begin
          for (int b = N - 1; b >= 0; b--) begin
            for (int d = 0; d < DIV; d++) expq.push_back({1'b0, data_q[8*b+p], 1'b0});
            for (int d = 0; d < DIV; d++) expq.push_back({1'b1, data_q[8*b+p], 1'b0});
          end
          for (int d = 0; d < DIV; d++) expq.push_back(3'b001);
        end
      end
      if (expq.size() > 0) begin
        logic [2:0] e;
        e = expq.pop_front();
        chk({sclk, sdata, latch} == e, "R5/R6", "wire pattern", {sclk, sdata, latch}, e);
        chk(in_ready == 1'b0, "R2", "ready low in frame", in_ready, 0);
        was_busy = 1'b1;
      end else begin
        chk(in_ready == 1'b1, was_busy ? "R7" : "R9", "ready after frame", in_ready, 1);
        chk({sclk, sdata, latch} == 3'b000, "R9", "idle wires", {sclk, sdata, latch}, 0);
        was_busy = 1'b0;
      end
      // external chain model
      if (sclk && !prev_sclk) chain = {chain[N-2:0], sdata};
      if (latch && !prev_latch) begin
        logic [N-1:0] w;
        for (int k = 0; k < N; k++) w[k] = fdata[8*k+plane_exp];
        chk(chain == w, "R4", "latched plane", chain, w);
        chk((cyc - pstart) < SLOT, "R8", "plane burst cycles", cyc - pstart, SLOT);
        plane_exp++;
        pstart = cyc + DIV;
      end
      prev_sclk  = sclk;
      prev_latch = latch;
    end
  end

  task automatic send(input logic [8*N-1:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready || expq.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [8*N-1:0] pat(input int kind);
    logic [8*N-1:0] v;
    for (int k = 0; k < N; k++) begin
      case (kind)
        0: v[8*k +: 8] = 8'(k * 17 + 3);
        1: v[8*k +: 8] = (k % 2) ? 8'hFF : 8'h00;
        2: v[8*k +: 8] = 8'(1 << (k % 8));
        default: v[8*k +: 8] = 8'(8'hA5 ^ k);
      endcase
    end
    return v;
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);
    chk({sclk, sdata, latch} == 3'b000, "R1", "wires in reset", {sclk, sdata, latch}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(pat(0));  wait_idle();
    send(pat(1));  wait_idle();
    send(pat(2));  wait_idle();

    // R3: offer other data throughout a frame
    send(pat(3));
    in_valid = 1'b1;
    in_data  = pat(0);
    repeat (FRAME - 20) @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    // R7: back-to-back with valid held; second set must follow immediately
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = pat(1);
    @(negedge clk);
    in_data  = pat(2);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    chk(frames == 6, "R2", "frames accepted", frames, 6);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule